// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Daisy-Chain Grant

This block decides when a processor takes an interrupt, which device gets it, and how the processor enters the service routine. Device request slices sit in a chain, with position 0 nearest the processor. Each slice latches a raise pulse from its device and holds a pending request at one of four urgency levels, 4 to 7. At an instruction-boundary strobe the arbiter compares the most urgent pending level with the 3-bit priority field of the current status word. If that level is strictly higher, the arbiter drives the matching grant line.

The grant travels down the chain. A slice with no request at that level passes the grant on. The first slice that holds a request at that level keeps the grant, drops its request and presents its vector address. The arbiter then runs a fixed memory sequence. It pushes the status word and then the program counter below the stack pointer. It reads the new program counter from the vector word and the new status word from the vector word plus 2, and hands all three values back to the processor with the mode field forced to kernel. If no slice takes the grant within a set number of cycles, the arbiter uses the trap vector at address 4 instead. A return strobe runs the reverse sequence: it pops the program counter, then the status word.

Top module: `irq_chain_arbiter`

## Requirements
- R1: After reset no grant line is driven, no request is pending, no memory access is made and `busy` is low.
- R2: A level L (4 to 7) may be granted only when L is greater than the priority field `cur_psw[7:5]`. With priority 7 nothing is granted.
- R3: When several levels above the priority are pending, the highest level is granted first. Lower pending levels stay pending.
- R4: Within one level the grant goes to the pending slice with the lowest chain index. Later slices at that level stay pending.
- R5: A pending request that is not granted stays pending until a grant clears it.
- R6: The slice that takes a grant clears its pending request in that cycle.
- R7: The entry sequence, one access per cycle, is: write the status word to SP-2, write the program counter to SP-4, read the vector address V, then read V+2. Memory read data returns one cycle after the read.
- R8: After the reads, `ctx_load` pulses for one cycle with `ctx_pc` = mem[V], `ctx_psw` = mem[V+2] with bits 15:14 (mode) cleared to kernel (00), and `ctx_sp` = SP-4.
- R9: If no slice takes a driven grant within `RESP_TIMEOUT` cycles, the grant drops and the entry sequence runs with V = 4. A request line with no device behind it (`stray_req`, bit k = level 4+k) produces this case.
- R10: `rti_go` in idle reads SP and then SP+2. `ctx_load` then gives `ctx_pc` = mem[SP], `ctx_psw` = mem[SP+2] unchanged and `ctx_sp` = SP+4. If `rti_go` and the strobe arrive together, `rti_go` wins.
- R11: Arbitration starts only on a cycle where `insn_boundary` is high. Pending requests do nothing without the strobe.
- R12: At most one grant line is high at a time. Bit k of `bus_grant` is level 4+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | Instruction-boundary strobe; arbitration is sampled here |
| rti_go | input | 1 | Start the return-from-interrupt pop sequence |
| cur_pc | input | WORD_W | Current program counter |
| cur_psw | input | WORD_W | Current status word; priority in bits 7:5 |
| cur_sp | input | WORD_W | Current stack pointer |
| dev_raise | input | NUM_DEV | One-cycle raise pulse per chain slice |
| dev_level | input | 2*NUM_DEV | Level code per slice (code c means level 4+c) |
| dev_vector | input | WORD_W*NUM_DEV | Vector address per slice |
| stray_req | input | 4 | Request lines that no device answers (bit k = level 4+k) |
| bus_grant | output | 4 | Grant lines into the chain, bit k = level 4+k |
| dev_pending | output | NUM_DEV | Pending request state per slice |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | WORD_W | Memory byte address |
| mem_wdata | output | WORD_W | Memory write data |
| mem_rdata | input | WORD_W | Memory read data, one cycle after `mem_rd` |
| ctx_load | output | 1 | One-cycle strobe: load `ctx_pc`, `ctx_psw`, `ctx_sp` |
| ctx_pc | output | WORD_W | New program counter |
| ctx_psw | output | WORD_W | New status word |
| ctx_sp | output | WORD_W | New stack pointer |
| busy | output | 1 | High while a sequence is running |

## Verification
The bench builds the block with four chain slices and `RESP_TIMEOUT` set to 8. With four slices, two slices can share one level, which tests chain order, and two other slices can sit at different levels, which tests level order. The short timeout keeps the stray-request case brief enough to count grant cycles one by one and to follow the trap-vector sequence to its end. The scoreboard queues every expected memory access and context load in order, so an access that is missing, extra or reordered appears as a mismatch.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int NUM_LEVELS = 4;
   localparam int PRIO_LSB   = 5;
   localparam int MODE_LSB   = 14;
   localparam logic [15:0] TRAP_VECTOR = 16'h0004;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_GRANT,
      ST_PUSH_ST,
      ST_PUSH_PC,
      ST_RD_PC,
      ST_RD_ST,
      ST_LOAD,
      ST_POP_PC,
      ST_POP_ST,
      ST_RLOAD
   } seq_state_t;
endpackage

// File: rtl/irq_dev_slice.sv
module irq_dev_slice
   import irq_arb_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  raise,
   input  logic [1:0]            level,
   input  logic [NUM_LEVELS-1:0] grant_in,
   output logic [NUM_LEVELS-1:0] grant_out,
   output logic                  absorb,
   output logic                  pending
);
   logic [NUM_LEVELS-1:0] own_line;

   assign own_line  = pending ? (NUM_LEVELS'(1) << level) : '0;
   assign absorb    = |(grant_in & own_line);
   assign grant_out = grant_in & ~own_line;

   always_ff @(posedge clk) begin
      if (!rst_n) pending <= 1'b0;
      else        pending <= raise | (pending & ~absorb);
   end

   AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      absorb |=> (!pending || $past(raise)));   // R6
   AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !absorb) |=> pending);         // R5
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
   import irq_arb_pkg::*;
(
   input  logic [NUM_LEVELS-1:0] lines,
   input  logic [2:0]            prio,
   output logic                  any,
   output logic [1:0]            sel
);
   always_comb begin
      any = 1'b0;
      sel = '0;
      for (int k = 0; k < NUM_LEVELS; k++) begin
         if (lines[k] && ((4'(k) + 4'd4) > {1'b0, prio})) begin
            any = 1'b1;
            sel = 2'(k);
         end
      end
   end
endmodule

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NUM_DEV      = 4,
   parameter int WORD_W       = 16,
   parameter int RESP_TIMEOUT = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      insn_boundary,
   input  logic                      rti_go,
   input  logic [WORD_W-1:0]         cur_pc,
   input  logic [WORD_W-1:0]         cur_psw,
   input  logic [WORD_W-1:0]         cur_sp,
   input  logic [NUM_DEV-1:0]        dev_raise,
   input  logic [2*NUM_DEV-1:0]      dev_level,
   input  logic [WORD_W*NUM_DEV-1:0] dev_vector,
   input  logic [NUM_LEVELS-1:0]     stray_req,
   output logic [NUM_LEVELS-1:0]     bus_grant,
   output logic [NUM_DEV-1:0]        dev_pending,
   output logic                      mem_rd,
   output logic                      mem_wr,
   output logic [WORD_W-1:0]         mem_addr,
   output logic [WORD_W-1:0]         mem_wdata,
   input  logic [WORD_W-1:0]         mem_rdata,
   output logic                      ctx_load,
   output logic [WORD_W-1:0]         ctx_pc,
   output logic [WORD_W-1:0]         ctx_psw,
   output logic [WORD_W-1:0]         ctx_sp,
   output logic                      busy
);
   localparam int TW = $clog2(RESP_TIMEOUT + 1);
   localparam logic [WORD_W-1:0] WSTEP = WORD_W'(2);

   initial begin
      assert (NUM_DEV >= 1) else $error("NUM_DEV must be at least 1");
      assert (WORD_W >= 16) else $error("WORD_W must hold mode and priority fields");
      assert (RESP_TIMEOUT >= 1) else $error("RESP_TIMEOUT must be positive");
   end

   // chain of grant slices
   logic [NUM_LEVELS-1:0] chain [0:NUM_DEV];
   logic [NUM_DEV-1:0]    absorb;
   logic [NUM_LEVELS-1:0] dev_lines;

   assign chain[0] = bus_grant;

   generate
      for (genvar i = 0; i < NUM_DEV; i++) begin : g_slice
         irq_dev_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .raise     (dev_raise[i]),
            .level     (dev_level[2*i +: 2]),
            .grant_in  (chain[i]),
            .grant_out (chain[i+1]),
            .absorb    (absorb[i]),
            .pending   (dev_pending[i])
         );
      end
   endgenerate

   logic [WORD_W-1:0] vec_sel;
   always_comb begin
      dev_lines = stray_req;
      vec_sel   = '0;
      for (int i = 0; i < NUM_DEV; i++) begin
         if (dev_pending[i]) dev_lines[dev_level[2*i +: 2]] = 1'b1;
         if (absorb[i])      vec_sel = vec_sel | dev_vector[WORD_W*i +: WORD_W];
      end
   end

   logic       pick_any;
   logic [1:0] pick_sel;

   irq_level_pick u_pick (
      .lines (dev_lines),
      .prio  (cur_psw[PRIO_LSB +: 3]),
      .any   (pick_any),
      .sel   (pick_sel)
   );

   // sequencer
   seq_state_t        state;
   logic [WORD_W-1:0] psw_q, pc_q, sp_q, vec_q, newpc_q;
   logic [1:0]        lvl_q;
   logic [TW-1:0]     tmo_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         psw_q   <= '0;
         pc_q    <= '0;
         sp_q    <= '0;
         vec_q   <= '0;
         newpc_q <= '0;
         lvl_q   <= '0;
         tmo_cnt <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               tmo_cnt <= '0;
               if (rti_go) begin
                  sp_q  <= cur_sp;
                  state <= ST_POP_PC;
               end else if (insn_boundary && pick_any) begin
                  psw_q <= cur_psw;
                  pc_q  <= cur_pc;
                  sp_q  <= cur_sp;
                  lvl_q <= pick_sel;
                  state <= ST_GRANT;
               end
            end
            ST_GRANT: begin
               if (|absorb) begin
                  vec_q <= vec_sel;
                  state <= ST_PUSH_ST;
               end else if (tmo_cnt == TW'(RESP_TIMEOUT - 1)) begin
                  vec_q <= WORD_W'(TRAP_VECTOR);
                  state <= ST_PUSH_ST;
               end else begin
                  tmo_cnt <= tmo_cnt + 1'b1;
               end
            end
            ST_PUSH_ST: state <= ST_PUSH_PC;
            ST_PUSH_PC: state <= ST_RD_PC;
            ST_RD_PC:   state <= ST_RD_ST;
            ST_RD_ST: begin
               newpc_q <= mem_rdata;
               state   <= ST_LOAD;
            end
            ST_POP_PC:  state <= ST_POP_ST;
            ST_POP_ST: begin
               newpc_q <= mem_rdata;
               state   <= ST_RLOAD;
            end
            default:    state <= ST_IDLE;
         endcase
      end
   end

   assign bus_grant = (state == ST_GRANT) ? (NUM_LEVELS'(1) << lvl_q) : '0;
   assign busy      = (state != ST_IDLE);

   always_comb begin
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      ctx_load  = 1'b0;
      ctx_pc    = newpc_q;
      ctx_psw   = mem_rdata;
      ctx_sp    = sp_q;
      case (state)
         ST_PUSH_ST: begin mem_wr = 1'b1; mem_addr = sp_q - WSTEP;        mem_wdata = psw_q; end
         ST_PUSH_PC: begin mem_wr = 1'b1; mem_addr = sp_q - (WSTEP << 1); mem_wdata = pc_q;  end
         ST_RD_PC:   begin mem_rd = 1'b1; mem_addr = vec_q; end
         ST_RD_ST:   begin mem_rd = 1'b1; mem_addr = vec_q + WSTEP; end
         ST_LOAD: begin
            ctx_load = 1'b1;
            ctx_psw[MODE_LSB +: 2] = 2'b00;
            ctx_sp   = sp_q - (WSTEP << 1);
         end
         ST_POP_PC:  begin mem_rd = 1'b1; mem_addr = sp_q; end
         ST_POP_ST:  begin mem_rd = 1'b1; mem_addr = sp_q + WSTEP; end
         ST_RLOAD: begin
            ctx_load = 1'b1;
            ctx_sp   = sp_q + (WSTEP << 1);
         end
         default: ;
      endcase
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_grant));                                                    // R12
   AST_GRANT_ABOVE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant != '0) |-> ({1'b0, psw_q[PRIO_LSB +: 3]} < ({2'b00, lvl_q} + 4'd4))); // R2
   AST_STROBE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(insn_boundary) || $past(rti_go)));                // R11
   AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_cnt < TW'(RESP_TIMEOUT));                                            // R9
   AST_SINGLE_TAKER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(absorb));                                                       // R4
endmodule

// File: tb/irq_chain_arbiter_test.sv
`timescale 1ns/1ps
module irq_chain_arbiter_test;
   localparam int ND  = 4;
   localparam int W   = 16;
   localparam int TMO = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic insn_boundary = 1'b0;
   logic rti_go = 1'b0;
   logic [W-1:0] cur_pc = 16'h0A00;
   logic [W-1:0] cur_psw = 16'h0060;
   logic [W-1:0] cur_sp = 16'h01F0;
   logic [ND-1:0] dev_raise = '0;
   logic [2*ND-1:0] dev_level = '0;
   logic [W*ND-1:0] dev_vector = {16'h004C, 16'h0048, 16'h0044, 16'h0040};
   logic [3:0] stray_req = '0;
   logic [3:0] bus_grant;
   logic [ND-1:0] dev_pending;
   logic mem_rd, mem_wr, ctx_load, busy;
   logic [W-1:0] mem_addr, mem_wdata, mem_rdata, ctx_pc, ctx_psw, ctx_sp;

   always #2 clk = ~clk;

   irq_chain_arbiter #(.NUM_DEV(ND), .WORD_W(W), .RESP_TIMEOUT(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .rti_go(rti_go),
      .cur_pc(cur_pc), .cur_psw(cur_psw), .cur_sp(cur_sp),
      .dev_raise(dev_raise), .dev_level(dev_level), .dev_vector(dev_vector),
      .stray_req(stray_req), .bus_grant(bus_grant), .dev_pending(dev_pending),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .ctx_load(ctx_load), .ctx_pc(ctx_pc),
      .ctx_psw(ctx_psw), .ctx_sp(ctx_sp), .busy(busy)
   );

   // read-only memory model: contents computed from the address
   function automatic logic [15:0] memval(input logic [15:0] a);
      if (a == 16'h0004) return 16'h2004;
      if (a == 16'h0006) return 16'hC0E0;
      if (a == 16'h0180) return 16'h3456;
      if (a == 16'h0182) return 16'hC0A0;
      if (a >= 16'h0040 && a <= 16'h004E) begin
         if (a[1]) return 16'hC000 | (a - 16'h0002);
         return 16'h1000 + a;
      end
      return 16'h0000;
   endfunction

   always @(posedge clk) if (mem_rd) mem_rdata <= memval(mem_addr);

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct {
      int          kind;   // 0 write, 1 read, 2 context load
      logic [15:0] a;
      logic [15:0] b;
      logic [15:0] c;
      string       req;
   } item_t;
   item_t q[$];

   task automatic push_item(input int k, input logic [15:0] a, b, c, input string req);
      item_t it;
      it.kind = k; it.a = a; it.b = b; it.c = c; it.req = req;
      q.push_back(it);
   endtask

   task automatic expect_entry(input logic [15:0] v, pc, psw, sp, input string req);
      logic [15:0] np;
      np = memval(v + 16'h0002);
      np[15:14] = 2'b00;
      push_item(0, sp - 16'h0002, psw, 16'h0, req);
      push_item(0, sp - 16'h0004, pc, 16'h0, req);
      push_item(1, v, 16'h0, 16'h0, req);
      push_item(1, v + 16'h0002, 16'h0, 16'h0, req);
      push_item(2, memval(v), np, sp - 16'h0004, req);
   endtask

   // monitor: pops expected items as the design produces them
   always @(negedge clk) begin
      if (rst_n && (mem_wr || mem_rd || ctx_load)) begin
         if (q.size() == 0) begin
            check(1'b0, "R11 unexpected access", {mem_addr, 16'h0}, 32'h0);
         end else begin
            item_t it;
            int kind_act;
            it = q.pop_front();
            kind_act = ctx_load ? 2 : (mem_rd ? 1 : 0);
            check(kind_act == it.kind, {it.req, " R7 access kind"}, 32'(kind_act), 32'(it.kind));
            if (it.kind == 0)
               check(mem_addr == it.a && mem_wdata == it.b, {it.req, " R7 write"},
                     {mem_addr, mem_wdata}, {it.a, it.b});
            else if (it.kind == 1)
               check(mem_addr == it.a, {it.req, " R7 read"}, 32'(mem_addr), 32'(it.a));
            else
               check(ctx_pc == it.a && ctx_psw == it.b && ctx_sp == it.c, {it.req, " R8 load"},
                     {ctx_pc, ctx_psw}, {it.a, it.b});
         end
      end
   end

   task automatic raise(input int i, input logic [1:0] code);
      @(negedge clk);
      dev_level[2*i +: 2] = code;
      dev_raise[i] = 1'b1;
      @(negedge clk);
      dev_raise[i] = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk);
      insn_boundary = 1'b1;
      @(negedge clk);
      insn_boundary = 1'b0;
   endtask

   task automatic wait_idle();
      int guard;
      guard = 0;
      repeat (2) @(negedge clk);
      while (busy && guard < 200) begin
         @(negedge clk);
         guard++;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(bus_grant == 4'b0, "R1 grant", 32'(bus_grant), 32'h0);
      check(dev_pending == 4'b0, "R1 pending", 32'(dev_pending), 32'h0);
      check(!busy, "R1 busy", 32'(busy), 32'h0);
      check(!mem_rd && !mem_wr && !ctx_load, "R1 memory idle", {mem_rd, mem_wr, ctx_load}, 32'h0);

      // basic entry: slice 0 at level 5 (code 1), priority 3
      raise(0, 2'd1);
      check(dev_pending == 4'b0001, "R5 pending after raise", 32'(dev_pending), 32'h1);
      expect_entry(16'h0040, cur_pc, cur_psw, cur_sp, "R7 basic");
      strobe();
      wait_idle();
      check(dev_pending == 4'b0000, "R6 winner cleared", 32'(dev_pending), 32'h0);

      // priority 7 blocks level 7
      cur_psw = 16'h00E0;
      raise(1, 2'd3);
      strobe();
      repeat (5) @(negedge clk);
      check(!busy && bus_grant == 4'b0, "R2 priority 7 blocks", {busy, bus_grant}, 32'h0);
      check(dev_pending == 4'b0010, "R5 request kept", 32'(dev_pending), 32'h2);
      cur_psw = 16'h00C0;
      expect_entry(16'h0044, cur_pc, cur_psw, cur_sp, "R5 later service");
      strobe();
      wait_idle();
      check(dev_pending == 4'b0000, "R6 deferred served", 32'(dev_pending), 32'h0);

      // level 6 equals priority 6: not granted
      raise(2, 2'd2);
      strobe();
      repeat (4) @(negedge clk);
      check(!busy, "R2 equal level not granted", 32'(busy), 32'h0);

      // highest level first: slice 2 level 6 vs slice 0 level 4
      cur_psw = 16'h0000;
      raise(0, 2'd0);
      expect_entry(16'h0048, cur_pc, cur_psw, cur_sp, "R3 higher first");
      strobe();
      wait_idle();
      check(dev_pending == 4'b0001, "R3 lower still pending", 32'(dev_pending), 32'h1);
      expect_entry(16'h0040, cur_pc, cur_psw, cur_sp, "R3 lower next");
      strobe();
      wait_idle();

      // chain order within level 5: slice 1 before slice 3
      raise(3, 2'd1);
      raise(1, 2'd1);
      expect_entry(16'h0044, cur_pc, cur_psw, cur_sp, "R4 nearest first");
      strobe();
      wait_idle();
      check(dev_pending == 4'b1000, "R4 farther stays", 32'(dev_pending), 32'h8);
      expect_entry(16'h004C, cur_pc, cur_psw, cur_sp, "R4 farther next");
      strobe();
      wait_idle();

      // no strobe, no arbitration
      raise(0, 2'd3);
      repeat (10) @(negedge clk);
      check(!busy && bus_grant == 4'b0, "R11 no strobe", {busy, bus_grant}, 32'h0);
      expect_entry(16'h0040, cur_pc, cur_psw, cur_sp, "R11 strobe serves");
      strobe();
      wait_idle();

      // stray request at level 6: timeout then trap vector 4
      begin
         int gcnt;
         int guard;
         stray_req = 4'b0100;
         expect_entry(16'h0004, cur_pc, cur_psw, cur_sp, "R9 trap");
         @(negedge clk);
         insn_boundary = 1'b1;
         @(negedge clk);
         insn_boundary = 1'b0;
         gcnt = (bus_grant == 4'b0100) ? 1 : 0;
         guard = 0;
         while (busy && guard < 200) begin
            @(negedge clk);
            if (bus_grant == 4'b0100) gcnt++;
            guard++;
         end
         stray_req = 4'b0000;
         check(gcnt == TMO, "R9 grant cycles", 32'(gcnt), 32'(TMO));
      end

      // return from interrupt, issued together with a strobe
      cur_sp = 16'h0180;
      raise(2, 2'd2);
      push_item(1, 16'h0180, 16'h0, 16'h0, "R10 pop pc");
      push_item(1, 16'h0182, 16'h0, 16'h0, "R10 pop psw");
      push_item(2, 16'h3456, 16'hC0A0, 16'h0184, "R10 load");
      @(negedge clk);
      rti_go = 1'b1;
      insn_boundary = 1'b1;
      @(negedge clk);
      rti_go = 1'b0;
      insn_boundary = 1'b0;
      wait_idle();
      check(dev_pending == 4'b0100, "R10 return before grant", 32'(dev_pending), 32'h4);
      expect_entry(16'h0048, cur_pc, cur_psw, cur_sp, "R10 then serve");
      strobe();
      wait_idle();

      repeat (3) @(negedge clk);
      check(q.size() == 0, "R7 all expected accesses seen", 32'(q.size()), 32'h0);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule